// File: doc/BRIEF.md
# Lockable GPIO Pad Mode Controller

A 32-pin memory-mapped GPIO register block behind a simple 32-bit register port. Each pin has one bit of output data and a two-bit pad mode. Together they set what the pad does: it floats (input), drives the data value in both directions (push-pull), pulls low only when the data is 0 (open-drain), or pulls high only when the data is 1 (open-source). For each pin the block produces a drive value and a drive enable, which go to an external tristate pad cell. Pad levels come back through a two-flop synchronizer and can be read from a data-in register.

The two mode registers are protected by a key register. The guard opens only when a fixed 16-bit key is written. While it is closed, every write to either mode register or to their set/clear aliases is dropped. Output data is not protected. It is changed through write-one-to-set and write-one-to-clear registers, so software never needs a read-modify-write cycle.

The register port has no wait states. A write takes effect at the clock edge where `reg_sel` and `reg_we` are both high. Read data is combinational from `reg_addr` while `reg_sel` is high and `reg_we` is low, and is zero at all other times.

Top module: `lockgpio_top`

## Requirements
- R1: After reset all pad modes are 00, output data is 0, the guard is closed, every `pad_oe` and `pad_do` bit is 0, and reads of the guard, both mode registers and data-in return 0 (pads held at 0).
- R2: A write to the guard register at offset 0x00 whose bits 15:0 equal 0xD42F opens the guard. Bits 31:16 of that write are ignored. While the guard is open, reading offset 0x00 returns 0x8000_0000 (bit 31 set, all other bits 0).
- R3: A guard write with bits 15:0 equal to 0x0000 closes the guard. A guard write with any other value in bits 15:0 leaves the guard state unchanged.
- R4: While the guard is closed, writes to offsets 0x08, 0x0C, 0x50, 0x54 and 0x58 change neither mode register and do not change the pad outputs.
- R5: While the guard is open, a write to offset 0x08 loads the whole high mode-bit register (mode1), and a write to 0x0C loads the whole low mode-bit register (mode0). Reads of these offsets return the current contents.
- R6: While the guard is open, each 1 bit written to 0x54 sets that pin's mode0 bit, each 1 bit written to 0x58 clears it, and each 1 bit written to 0x50 clears that pin's mode1 bit. Bits written as 0 leave their pins unchanged.
- R7: Each 1 bit written to 0x14 sets that pin's output data bit, and each 1 bit written to 0x18 clears it. Bits written as 0 leave their pins unchanged. These writes work whether the guard is open or closed.
- R8: With mode {mode1,mode0} = 00, the pin's `pad_oe` is 0 for either data value. `pad_do` is 0 whenever `pad_oe` is 0.
- R9: With mode 01, `pad_oe` is 1 and `pad_do` equals the data bit.
- R10: With mode 10, data 0 gives `pad_oe`=1 and `pad_do`=0, and data 1 gives `pad_oe`=0.
- R11: With mode 11, data 1 gives `pad_oe`=1 and `pad_do`=1, and data 0 gives `pad_oe`=0.
- R12: A read of offset 0x04 returns `pad_di` as it was before two rising clock edges. A change on `pad_di` is not visible after only one edge.
- R13: Reads of any offset other than 0x00, 0x04, 0x08 and 0x0C return 0. This includes the write-only offsets 0x14, 0x18, 0x50, 0x54 and 0x58.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access select |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| pad_di | input | 32 | Raw pad input levels |
| pad_do | output | 32 | Per-pin drive value |
| pad_oe | output | 32 | Per-pin drive enable |

## Verification
The pad decode is tried in two ways. First, every pin is placed in the same mode and data, for all eight combinations, which separates the four behaviours from each other and confirms the data value is routed through. Then mixed patterns give neighbouring pins different modes and data, which exposes swapped mode bits or a pin reading the wrong register bit. The directed part covers several cases:
- keys that are almost right, with the guard left closed;
- mode writes that must be dropped, read back through the mode registers and checked again at the pad outputs;
- alias writes that touch only some pins;
- the synchronizer latency, sampled after zero, one and two edges.

// File: rtl/lockgpio_pkg.sv
package lockgpio_pkg;

   localparam int unsigned WORD_W = 32;

   // register offsets (byte addresses)
   localparam logic [7:0] OFS_GUARD   = 8'h00;
   localparam logic [7:0] OFS_DIN     = 8'h04;
   localparam logic [7:0] OFS_MODE_HI = 8'h08;
   localparam logic [7:0] OFS_MODE_LO = 8'h0C;
   localparam logic [7:0] OFS_DSET    = 8'h14;
   localparam logic [7:0] OFS_DCLR    = 8'h18;
   localparam logic [7:0] OFS_HI_CLR  = 8'h50;
   localparam logic [7:0] OFS_LO_SET  = 8'h54;
   localparam logic [7:0] OFS_LO_CLR  = 8'h58;

   // pad behaviour selected by {mode1,mode0}
   typedef enum logic [1:0] {
      PM_FLOAT  = 2'b00,
      PM_PUSH   = 2'b01,
      PM_SINK   = 2'b10,
      PM_SOURCE = 2'b11
   } pad_mode_e;

   // which mode-register operation a write performs
   typedef enum logic [2:0] {
      MW_NONE,
      MW_HI_LOAD,
      MW_LO_LOAD,
      MW_HI_CLR,
      MW_LO_SET,
      MW_LO_CLR
   } mode_wr_e;

endpackage

// File: rtl/lockgpio_guard.sv
module lockgpio_guard #(
   parameter int unsigned KEY_W = 16,
   parameter logic [KEY_W-1:0] OPEN_KEY = 16'hD42F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [KEY_W-1:0] wr_key,
   output logic             open_o
);

   if (KEY_W < 1 || KEY_W > 31) begin : g_bad_key
      $error("lockgpio_guard: KEY_W must be 1..31");
   end

   localparam logic [KEY_W-1:0] CLOSE_KEY = '0;

   logic open_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         open_q <= 1'b0;
      else if (wr_en) begin
         if (wr_key == OPEN_KEY)
            open_q <= 1'b1;
         else if (wr_key == CLOSE_KEY)
            open_q <= 1'b0;
      end
   end

   assign open_o = open_q;

   a_r2_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_key == OPEN_KEY) |=> open_o);

   a_r3_zero_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_key == CLOSE_KEY) |=> !open_o);

   a_r3_other_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || (wr_key != OPEN_KEY && wr_key != CLOSE_KEY)) |=> $stable(open_o));

endmodule

// File: rtl/lockgpio_mode_regs.sv
module lockgpio_mode_regs
   import lockgpio_pkg::*;
#(
   parameter int unsigned NUM_PINS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                guard_open,
   input  mode_wr_e            wr_op,
   input  logic [NUM_PINS-1:0] wr_bits,
   output logic [NUM_PINS-1:0] mode_hi,
   output logic [NUM_PINS-1:0] mode_lo
);

   logic [NUM_PINS-1:0] hi_q, lo_q;
   logic [NUM_PINS-1:0] hi_d, lo_d;

   always_comb begin
      hi_d = hi_q;
      lo_d = lo_q;
      if (guard_open) begin
         unique case (wr_op)
            MW_HI_LOAD: hi_d = wr_bits;
            MW_LO_LOAD: lo_d = wr_bits;
            MW_HI_CLR:  hi_d = hi_q & ~wr_bits;
            MW_LO_SET:  lo_d = lo_q | wr_bits;
            MW_LO_CLR:  lo_d = lo_q & ~wr_bits;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else begin
         hi_q <= hi_d;
         lo_q <= lo_d;
      end
   end

   assign mode_hi = hi_q;
   assign mode_lo = lo_q;

   a_r4_closed_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !guard_open |=> ($stable(mode_hi) && $stable(mode_lo)));

   a_r6_lo_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (guard_open && wr_op == MW_LO_SET) |=>
         (((mode_lo & $past(wr_bits)) == $past(wr_bits)) && $stable(mode_hi)));

   a_r6_hi_clr_lowers: assert property (@(posedge clk) disable iff (!rst_n)
      (guard_open && wr_op == MW_HI_CLR) |=>
         (((mode_hi & $past(wr_bits)) == '0) && $stable(mode_lo)));

   a_r5_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
      (guard_open && wr_op == MW_LO_LOAD) |=> (mode_lo == $past(wr_bits)));

endmodule

// File: rtl/lockgpio_pad_decode.sv
module lockgpio_pad_decode
   import lockgpio_pkg::*;
#(
   parameter int unsigned NUM_PINS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] mode_hi,
   input  logic [NUM_PINS-1:0] mode_lo,
   input  logic [NUM_PINS-1:0] dout,
   output logic [NUM_PINS-1:0] drv_val,
   output logic [NUM_PINS-1:0] drv_en
);

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      pad_mode_e mode;
      logic en, val;

      assign mode = pad_mode_e'({mode_hi[p], mode_lo[p]});

      always_comb begin
         en  = 1'b0;
         val = 1'b0;
         unique case (mode)
            PM_FLOAT:  begin en = 1'b0;     val = 1'b0;    end
            PM_PUSH:   begin en = 1'b1;     val = dout[p]; end
            PM_SINK:   begin en = ~dout[p]; val = 1'b0;    end
            PM_SOURCE: begin en = dout[p];  val = dout[p]; end
            default:   begin en = 1'b0;     val = 1'b0;    end
         endcase
      end

      assign drv_en[p]  = en;
      assign drv_val[p] = val & en;
   end

   a_r8_float_never_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en & ~mode_hi & ~mode_lo) == '0);

   a_r8_idle_value_low: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_val & ~drv_en) == '0);

   a_r10_sink_only_low: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_val & mode_hi & ~mode_lo) == '0);

   a_r11_source_only_high: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en & ~drv_val & mode_hi & mode_lo) == '0);

endmodule

// File: rtl/lockgpio_in_sync.sv
module lockgpio_in_sync #(
   parameter int unsigned NUM_PINS = 32,
   parameter int unsigned STAGES   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] raw_in,
   output logic [NUM_PINS-1:0] sync_out
);

   if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
      $error("lockgpio_in_sync: STAGES must be 2..4");
   end

   logic [STAGES-1:0][NUM_PINS-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         chain <= '0;
      else
         chain <= {chain[STAGES-2:0], raw_in};
   end

   assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/lockgpio_top.sv
module lockgpio_top
   import lockgpio_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [15:0] OPEN_KEY    = 16'hD42F
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_sel,
   input  logic                reg_we,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [WORD_W-1:0]   reg_wdata,
   output logic [WORD_W-1:0]   reg_rdata,
   input  logic [NUM_PINS-1:0] pad_di,
   output logic [NUM_PINS-1:0] pad_do,
   output logic [NUM_PINS-1:0] pad_oe
);

   if (NUM_PINS < 1 || NUM_PINS > WORD_W) begin : g_bad_pins
      $error("lockgpio_top: NUM_PINS must be 1..32");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("lockgpio_top: ADDR_W must be at least 8");
   end

   localparam int unsigned KEY_W      = 16;
   localparam int unsigned STATUS_BIT = WORD_W - 1;

   logic                wr_strobe, rd_strobe;
   logic                hit_guard, hit_din, hit_mhi, hit_mlo;
   logic                hit_dset, hit_dclr, hit_hclr, hit_lset, hit_lclr;
   logic                guard_open;
   mode_wr_e            mode_op;
   logic [NUM_PINS-1:0] wr_pins;
   logic [NUM_PINS-1:0] mode_hi, mode_lo;
   logic [NUM_PINS-1:0] dout_q;
   logic [NUM_PINS-1:0] din_sync;

   assign wr_strobe = reg_sel &  reg_we;
   assign rd_strobe = reg_sel & ~reg_we;
   assign wr_pins   = reg_wdata[NUM_PINS-1:0];

   assign hit_guard = (reg_addr == ADDR_W'(OFS_GUARD));
   assign hit_din   = (reg_addr == ADDR_W'(OFS_DIN));
   assign hit_mhi   = (reg_addr == ADDR_W'(OFS_MODE_HI));
   assign hit_mlo   = (reg_addr == ADDR_W'(OFS_MODE_LO));
   assign hit_dset  = (reg_addr == ADDR_W'(OFS_DSET));
   assign hit_dclr  = (reg_addr == ADDR_W'(OFS_DCLR));
   assign hit_hclr  = (reg_addr == ADDR_W'(OFS_HI_CLR));
   assign hit_lset  = (reg_addr == ADDR_W'(OFS_LO_SET));
   assign hit_lclr  = (reg_addr == ADDR_W'(OFS_LO_CLR));

   always_comb begin
      mode_op = MW_NONE;
      if (wr_strobe) begin
         if (hit_mhi)       mode_op = MW_HI_LOAD;
         else if (hit_mlo)  mode_op = MW_LO_LOAD;
         else if (hit_hclr) mode_op = MW_HI_CLR;
         else if (hit_lset) mode_op = MW_LO_SET;
         else if (hit_lclr) mode_op = MW_LO_CLR;
      end
   end

   lockgpio_guard #(
      .KEY_W    (KEY_W),
      .OPEN_KEY (OPEN_KEY)
   ) u_guard (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_strobe & hit_guard),
      .wr_key (reg_wdata[KEY_W-1:0]),
      .open_o (guard_open)
   );

   lockgpio_mode_regs #(
      .NUM_PINS (NUM_PINS)
   ) u_modes (
      .clk        (clk),
      .rst_n      (rst_n),
      .guard_open (guard_open),
      .wr_op      (mode_op),
      .wr_bits    (wr_pins),
      .mode_hi    (mode_hi),
      .mode_lo    (mode_lo)
   );

   // output data: write-one-to-set / write-one-to-clear, not guarded
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dout_q <= '0;
      else if (wr_strobe && hit_dset)
         dout_q <= dout_q | wr_pins;
      else if (wr_strobe && hit_dclr)
         dout_q <= dout_q & ~wr_pins;
   end

   lockgpio_pad_decode #(
      .NUM_PINS (NUM_PINS)
   ) u_decode (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_hi (mode_hi),
      .mode_lo (mode_lo),
      .dout    (dout_q),
      .drv_val (pad_do),
      .drv_en  (pad_oe)
   );

   lockgpio_in_sync #(
      .NUM_PINS (NUM_PINS),
      .STAGES   (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (pad_di),
      .sync_out (din_sync)
   );

   always_comb begin
      reg_rdata = '0;
      if (rd_strobe) begin
         if (hit_guard)    reg_rdata[STATUS_BIT] = guard_open;
         else if (hit_din) reg_rdata = WORD_W'(din_sync);
         else if (hit_mhi) reg_rdata = WORD_W'(mode_hi);
         else if (hit_mlo) reg_rdata = WORD_W'(mode_lo);
      end
   end

   a_r7_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strobe && hit_dset) |=> ((dout_q & $past(wr_pins)) == $past(wr_pins)));

   a_r7_clr_lowers: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strobe && hit_dclr) |=> ((dout_q & $past(wr_pins)) == '0));

   a_r13_idle_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_strobe |-> (reg_rdata == '0));

endmodule

// File: tb/sim_lockgpio_top.sv
module sim_lockgpio_top;

   localparam int unsigned NP = 32;
   localparam int unsigned WATCHDOG = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_sel = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [NP-1:0] pad_di = '0;
   logic [NP-1:0] pad_do, pad_oe;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   lockgpio_top u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_sel   (reg_sel),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pad_di    (pad_di),
      .pad_do    (pad_do),
      .pad_oe    (pad_oe)
   );

   // {mode1, mode0, data} patterns
   localparam int NV = 11;
   localparam logic [95:0] VEC [0:NV-1] = '{
      {32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
      {32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF},
      {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000},
      {32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
      {32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000},
      {32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF},
      {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000},
      {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
      {32'hCCCC_CCCC, 32'hAAAA_AAAA, 32'hF0F0_F0F0},
      {32'h0F0F_3355, 32'h00FF_5A5A, 32'h1234_ABCD},
      {32'h8000_0001, 32'h4000_0003, 32'hC000_0002}
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_sel = 1'b0; reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
      #1 d = reg_rdata;
      reg_sel = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d expected <%0d cycles", cycles, WATCHDOG);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] r, m1, m0, dd, eoe, edo;

      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "pad_oe", pad_oe, '0);
      check("R1", "pad_do", pad_do, '0);
      rd(8'h00, r); check("R1", "guard read", r, '0);
      rd(8'h08, r); check("R1", "mode1 read", r, '0);
      rd(8'h0C, r); check("R1", "mode0 read", r, '0);
      rst_n = 1'b1;
      rd(8'h04, r); check("R1", "data-in read", r, '0);

      // R2 open with key, upper bits ignored
      wr(8'h00, 32'h1234_D42F);
      rd(8'h00, r); check("R2", "guard open status", r, 32'h8000_0000);

      // R8/R9/R10/R11 table walk
      for (int i = 0; i < NV; i++) begin
         m1 = VEC[i][95:64]; m0 = VEC[i][63:32]; dd = VEC[i][31:0];
         wr(8'h08, m1);
         wr(8'h0C, m0);
         wr(8'h18, 32'hFFFF_FFFF);
         wr(8'h14, dd);
         eoe = (~m1 & m0) | (m1 & ~m0 & ~dd) | (m1 & m0 & dd);
         edo = eoe & ((~m1 & m0 & dd) | (m1 & m0));
         @(negedge clk);
         check("R8/R9/R10/R11", $sformatf("oe vec %0d", i), pad_oe, eoe);
         check("R8/R9/R10/R11", $sformatf("do vec %0d", i), pad_do, edo);
      end

      // R5 readback of direct loads
      wr(8'h08, 32'h0000_FFFF);
      wr(8'h0C, 32'h00FF_00FF);
      rd(8'h08, r); check("R5", "mode1 readback", r, 32'h0000_FFFF);
      rd(8'h0C, r); check("R5", "mode0 readback", r, 32'h00FF_00FF);

      // R6 aliases touch only selected pins
      wr(8'h54, 32'hF000_0000);
      rd(8'h0C, r); check("R6", "mode0 set alias", r, 32'hF0FF_00FF);
      wr(8'h58, 32'h0000_000F);
      rd(8'h0C, r); check("R6", "mode0 clear alias", r, 32'hF0FF_00F0);
      wr(8'h50, 32'h0000_00F0);
      rd(8'h08, r); check("R6", "mode1 clear alias", r, 32'h0000_FF0F);

      // R3 bad key keeps guard open; zero closes it
      wr(8'h00, 32'h0000_D42E);
      rd(8'h00, r); check("R3", "near key keeps open", r, 32'h8000_0000);
      wr(8'h00, 32'hABCD_0000);
      rd(8'h00, r); check("R3", "zero key closes", r, 32'h0000_0000);
      wr(8'h00, 32'h0000_42D4);
      rd(8'h00, r); check("R3", "bad key stays closed", r, 32'h0000_0000);

      // R4 guarded writes dropped; pads unchanged
      wr(8'h08, 32'h0000_0000);
      wr(8'h0C, 32'hFFFF_FFFF);
      wr(8'h54, 32'hFFFF_FFFF);
      wr(8'h58, 32'hFFFF_FFFF);
      wr(8'h50, 32'hFFFF_FFFF);
      rd(8'h08, r); check("R4", "mode1 held", r, 32'h0000_FF0F);
      rd(8'h0C, r); check("R4", "mode0 held", r, 32'hF0FF_00F0);

      // R7 data writes not guarded; all pins push-pull for visibility
      wr(8'h00, 32'h0000_D42F);
      wr(8'h08, 32'h0);
      wr(8'h0C, 32'hFFFF_FFFF);
      wr(8'h00, 32'h0);
      wr(8'h18, 32'hFFFF_FFFF);
      wr(8'h14, 32'h0000_00A5);
      @(negedge clk);
      check("R7", "set with guard closed", pad_do, 32'h0000_00A5);
      wr(8'h14, 32'h0000_0F00);
      @(negedge clk);
      check("R7", "set leaves zeros alone", pad_do, 32'h0000_0FA5);
      wr(8'h18, 32'h0000_0081);
      @(negedge clk);
      check("R7", "clear only ones", pad_do, 32'h0000_0F24);
      check("R4", "oe after dropped writes", pad_oe, 32'hFFFF_FFFF);

      // R12 two-edge synchronizer latency
      @(negedge clk);
      pad_di = 32'h5A5A_C3C3;
      reg_sel = 1'b1; reg_we = 1'b0; reg_addr = 8'h04;
      #1 check("R12", "no edge yet", reg_rdata, 32'h0000_0000);
      @(negedge clk); #1 check("R12", "after one edge", reg_rdata, 32'h0000_0000);
      @(negedge clk); #1 check("R12", "after two edges", reg_rdata, 32'h5A5A_C3C3);
      reg_sel = 1'b0;

      // R13 unmapped and write-only offsets read as zero
      rd(8'h14, r); check("R13", "read 0x14", r, '0);
      rd(8'h54, r); check("R13", "read 0x54", r, '0);
      rd(8'h40, r); check("R13", "read 0x40", r, '0);
      rd(8'hFC, r); check("R13", "read 0xFC", r, '0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule